// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Routing

This block holds the interrupt state of a serial port controller. Eleven interrupt sources share one raw status word. The receive FIFO, transmit path and modem logic set these bits with single-cycle pulses. A write of the data register also raises the transmit bit. Software clears bits by writing ones to a clear address.

An enable mask picks which pending bits may reach the interrupt lines. Software sees three views of the one status word: the raw status, the masked status (raw AND mask) and the write-only clear address.

Six registered interrupt lines leave the block:
- one combined line, which is the OR of every enabled pending bit;
- one line each for the modem status, receive, transmit, receive-timeout and error groups.

The register bus attaches to the simple write and read ports. The FIFO and modem logic attach to the set-pulse input.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the raw status and the enable mask are zero, every read returns zero and all six interrupt lines are low.
- R2: A read of address 4 (masked view) returns the raw status ANDed with the enable mask, zero-extended to 32 bits.
- R3: A write to address 5 (clear) removes every raw status bit written as one and leaves the other bits unchanged. A read of address 5 returns zero.
- R4: Writes to address 3 (raw view) and address 4 (masked view) change neither the raw status nor the enable mask.
- R5: Any write to address 0 (data) sets raw bit 5 (transmit), whatever the written value.
- R6: Each bit set on `set_evt` sets the same raw bit at the next edge. A set pulse wins over a clear of the same bit in the same cycle. Address 3 reads the raw status.
- R7: `irq_any_o` is high exactly when any bit 0 to 10 of raw AND mask is set.
- R8: Each group line is high exactly when its own bits of raw AND mask are non-zero:
  - modem status: bits 0-3 (ring, clear-to-send, carrier detect, data-set-ready);
  - receive: bit 4;
  - transmit: bit 5;
  - receive timeout: bit 6;
  - error: bits 7-10.
- R9: The interrupt lines are registered. They reflect the state produced by an event from the first clock edge that follows it.
- R10: A write to address 2 replaces the 11-bit enable mask. A read of address 2 returns the mask.
- R11: A write to address 1 (control) changes neither the raw status nor the mask. Addresses 0, 1 and 6 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| set_evt | input | 11 | Per-source set pulses from FIFO and modem logic |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_any_o | output | 1 | Combined interrupt line |
| irq_ms_o | output | 1 | Modem status interrupt line |
| irq_rx_o | output | 1 | Receive interrupt line |
| irq_tx_o | output | 1 | Transmit interrupt line |
| irq_rt_o | output | 1 | Receive-timeout interrupt line |
| irq_err_o | output | 1 | Error interrupt line |

## Verification
The hardest situation to reach from the ports is a set pulse and a clear write that hit the same bit in the same cycle. Only that case tests the set-over-clear priority. Random stimulus rarely lines the two up. So directed steps drive a clear of all ones together with chosen set patterns. The random phase then keeps set pulses running during a large share of its clear writes. Changes of the mask while bits are pending get similar care, so that each group line is seen to rise and fall through the mask alone.

// File: rtl/uart_irq_router.sv
`timescale 1ns/1ps
module uart_irq_router #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_SRC-1:0] set_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_any_o,
  output logic              irq_ms_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_rt_o,
  output logic              irq_err_o
);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(5);

  localparam logic [NUM_SRC-1:0] G_MS  = NUM_SRC'('h00F);
  localparam logic [NUM_SRC-1:0] G_RX  = NUM_SRC'('h010);
  localparam logic [NUM_SRC-1:0] G_TX  = NUM_SRC'('h020);
  localparam logic [NUM_SRC-1:0] G_RT  = NUM_SRC'('h040);
  localparam logic [NUM_SRC-1:0] G_ERR = NUM_SRC'('h780);

  logic [NUM_SRC-1:0] raw, mask;
  logic [NUM_SRC-1:0] raw_nxt, mask_nxt, pend_nxt, clr_bits, tx_bit;

  wire hit_data  = wr_en && (wr_addr == A_DATA);
  wire hit_mask  = wr_en && (wr_addr == A_MASK);
  wire hit_clear = wr_en && (wr_addr == A_CLEAR);

  assign clr_bits = hit_clear ? wr_data[NUM_SRC-1:0] : '0;
  assign tx_bit   = hit_data ? G_TX : '0;
  assign raw_nxt  = (raw & ~clr_bits) | set_evt | tx_bit;
  assign mask_nxt = hit_mask ? wr_data[NUM_SRC-1:0] : mask;
  assign pend_nxt = raw_nxt & mask_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw       <= '0;
      mask      <= '0;
      irq_any_o <= 1'b0;
      irq_ms_o  <= 1'b0;
      irq_rx_o  <= 1'b0;
      irq_tx_o  <= 1'b0;
      irq_rt_o  <= 1'b0;
      irq_err_o <= 1'b0;
    end else begin
      raw       <= raw_nxt;
      mask      <= mask_nxt;
      irq_any_o <= |pend_nxt;
      irq_ms_o  <= |(pend_nxt & G_MS);
      irq_rx_o  <= |(pend_nxt & G_RX);
      irq_tx_o  <= |(pend_nxt & G_TX);
      irq_rt_o  <= |(pend_nxt & G_RT);
      irq_err_o <= |(pend_nxt & G_ERR);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MASK:   rd_data[NUM_SRC-1:0] = mask;
      A_RAW:    rd_data[NUM_SRC-1:0] = raw;
      A_MASKED: rd_data[NUM_SRC-1:0] = raw & mask;
      default:  rd_data = '0;
    endcase
  end

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clear && set_evt == '0) |=> ((raw & $past(wr_data[NUM_SRC-1:0])) == '0)); // R3
  AST_RO_VIEWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_RAW || wr_addr == A_MASKED) && set_evt == '0) |=> ($stable(raw) && $stable(mask))); // R4
  AST_DATA_TX: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data |=> raw[5]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((raw & $past(set_evt)) == $past(set_evt))); // R6
  AST_ANY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_o == (irq_ms_o || irq_rx_o || irq_tx_o || irq_rt_o || irq_err_o)); // R7
  AST_RX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_o == (raw[4] && mask[4])); // R8
  AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && set_evt == '0) |=> ($stable(raw) && $stable(mask))); // R11
endmodule

// File: tb/uart_irq_router_tb.sv
`timescale 1ns/1ps
module uart_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [10:0] set_evt = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_any_o, irq_ms_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_err_o;

  int n_chk = 0;
  int n_err = 0;
  logic [10:0] m_raw = '0;
  logic [10:0] m_mask = '0;

  always #2 clk = ~clk;

  uart_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_evt(set_evt), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_any_o(irq_any_o), .irq_ms_o(irq_ms_o), .irq_rx_o(irq_rx_o),
    .irq_tx_o(irq_tx_o), .irq_rt_o(irq_rt_o), .irq_err_o(irq_err_o)
  );

  function automatic logic [5:0] route(input logic [10:0] p);
    return {|p, |p[3:0], p[4], p[5], p[6], |p[10:7]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic check_state();
    logic [31:0] v;
    chk("R8", {26'd0, irq_ms_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_err_o},
        {26'd0, route(m_raw & m_mask) & 6'h1f});
    chk("R7", {31'd0, irq_any_o}, {31'd0, route(m_raw & m_mask) >> 5});
    rd(4'd3, v); chk("R6", v, {21'd0, m_raw});
    rd(4'd2, v); chk("R10", v, {21'd0, m_mask});
    rd(4'd4, v); chk("R2", v, {21'd0, m_raw & m_mask});
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d,
                      input logic [10:0] s);
    logic [10:0] nr;
    wr_en = we; wr_addr = a; wr_data = d; set_evt = s;
    nr = m_raw;
    if (we && a == 4'd5) nr &= ~d[10:0];
    nr |= s;
    if (we && a == 4'd0) nr[5] = 1'b1;
    if (we && a == 4'd2) m_mask = d[10:0];
    m_raw = nr;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; set_evt = '0;
    check_state();
  endtask

  task automatic do_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_raw = '0; m_mask = '0;
    chk("R1", {26'd0, irq_any_o, irq_ms_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_err_o}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1", v, 32'd0);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R9: the line follows at the very next edge
    step(1, 4'd2, 32'h7FF, '0);
    step(0, 4'd0, 0, 11'h010);
    chk("R9", {31'd0, irq_rx_o}, 32'd1);
    // R5: a data write of zero still raises transmit
    step(1, 4'd0, 32'h0, '0);
    chk("R5", {31'd0, irq_tx_o}, 32'd1);
    // R3: clear of one bit leaves the other; the clear address reads zero
    step(1, 4'd5, 32'h010, '0);
    chk("R3", {21'd0, m_raw}, 32'h020);
    rd(4'd5, v); chk("R3", v, 32'd0);
    // R4: writes to the views are ignored
    step(1, 4'd3, 32'hFFFF_FFFF, '0);
    step(1, 4'd4, 32'h0, '0);
    rd(4'd3, v); chk("R4", v, 32'h020);
    rd(4'd2, v); chk("R4", v, 32'h7FF);
    // R11: control writes touch nothing; data and control read zero
    step(1, 4'd1, 32'hFFFF_FFFF, '0);
    rd(4'd3, v); chk("R11", v, 32'h020);
    rd(4'd0, v); chk("R11", v, 32'd0);
    rd(4'd1, v); chk("R11", v, 32'd0);
    rd(4'd9, v); chk("R11", v, 32'd0);
    // R6: set beats clear on the same bits
    step(1, 4'd5, 32'h7FF, 11'h481);
    chk("R6", {21'd0, m_raw}, 32'h481);
    // R8: each group alone via the mask
    step(1, 4'd5, 32'h7FF, 11'h7FF);
    step(1, 4'd2, 32'h008, '0);
    chk("R8", {26'd0, irq_any_o, irq_ms_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_err_o}, 32'h30);
    step(1, 4'd2, 32'h040, '0);
    chk("R8", {26'd0, irq_any_o, irq_ms_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_err_o}, 32'h22);
    step(1, 4'd2, 32'h200, '0);
    chk("R8", {26'd0, irq_any_o, irq_ms_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_err_o}, 32'h21);
    step(1, 4'd2, 32'h000, '0);
    chk("R7", {31'd0, irq_any_o}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [10:0] s;
      op = int'($urandom_range(0, 9));
      s = ($urandom_range(0, 2) == 0) ? 11'($urandom) : '0;
      case (op)
        0: step(1, 4'd0, $urandom, s);
        1: step(1, 4'd1, $urandom, s);
        2, 3: step(1, 4'd2, $urandom, s);
        4: step(1, 4'd3, $urandom, s);
        5: step(1, 4'd4, $urandom, s);
        6, 7: step(1, 4'd5, $urandom, 11'($urandom));
        8: step(1, 4'($urandom_range(6, 15)), $urandom, s);
        default: step(0, 4'd0, 0, s);
      endcase
    end

    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule